// File: doc/BRIEF.md
# Fractional-Increment Realtime Counter

This block keeps a 64-bit master count that advances at a chosen average rate, independent of the frequency of the system clock that drives it. On every clock a 12-bit step value is added to a fractional accumulator. Whenever the accumulator reaches a 12-bit modulus, the modulus is taken off and the count advances by one. The average count rate is therefore the clock rate times step/modulus.

Software picks the ratio that suits the system clock. Some examples: 4/25 for 38.4 MHz, 64/125 for 12 MHz, 8/25 for 19.2 MHz, 192/625 for 20 MHz, 768/1625 for 13 MHz, 384/1625 for 26 MHz and 256/1125 for 27 MHz. Each of these gives a nominal 6.144 MHz count. The ratio 75/244 covers a 32 kHz reference that is emulated from the system clock.

The count is always present on a 64-bit output. It can also be read over a simple register port as two 32-bit halves, and a read of the low half captures the high half at the same moment.

On each clock the accumulator takes one of three named outcomes. STEP_HOLD: the sum stays below the modulus, so the count holds and the sum is kept. STEP_ADVANCE: the count advances and the remainder is kept. STEP_RESYNC: the count advances and the accumulator restarts from zero because the remainder is still not below the modulus. Each clock moves from the current outcome to the next one purely from the accumulator, step and modulus values.

Top module: `rt_frac_counter`

## Requirements
- R1: After reset the count is 0, the accumulator is 0, the step register reads 4 and the modulus register reads 25.
- R2: Each clock the accumulator adds the step value; from a zero accumulator with a fixed ratio n/d, the count after k clocks equals floor(k*n/d).
- R3: The count never changes by more than one per clock and never decreases.
- R4: A write to offset 0x10 sets the step value from write-data bits [11:0]; bits [31:12] always read as zero; writes elsewhere leave the step unchanged.
- R5: A write to offset 0x14 sets the modulus from write-data bits [11:0]; bits [31:12] always read as zero; writes elsewhere leave the modulus unchanged.
- R6: A written ratio governs the count from the clock after the write. If the accumulator is not below the new modulus, it is first clamped to the modulus minus one, so that at most one advance follows.
- R7: If the step is not below the modulus (including a modulus of 0), the count advances on every clock and the accumulator restarts from zero whenever the remainder is not below the modulus.
- R8: A read of offset 0x00 returns count bits [31:0] and captures count bits [63:32]. A read of offset 0x04 returns the captured value, which changes only on a read of 0x00 and is 0 after reset.
- R9: Read data appears on the clock after the read request and reflects the state before that edge. A read of an unmapped offset returns 0, and read data is 0 on any clock that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the clock after a read |
| mc_count_o | output | 64 | Master count |

## Verification
A ratio write can land on the same clock as an accumulator step. The old ratio must govern that step, and the new one must govern the next. The bench provokes this by writing a much smaller modulus while the accumulator holds a large remainder, and its behavioural model flags any lost, doubled or early advance on every clock. A read can also share a clock edge with a count advance. A low-half read issued while the count is moving must return the value from before the edge; the model compares each read result with its own pre-edge count.

// File: rtl/rtfc_pkg.sv
package rtfc_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STEP   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MOD    = 6'h14;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_ADVANCE,
        STEP_RESYNC
    } step_e;
endpackage

// File: rtl/rtfc_ratio_regs.sv
module rtfc_ratio_regs
    import rtfc_pkg::*;
#(
    parameter int RATIO_W = 12,
    parameter int STEP_RST = 4,
    parameter int MOD_RST = 25
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [RATIO_W-1:0]   wfield_i,
    output logic [RATIO_W-1:0]   step_o,
    output logic [RATIO_W-1:0]   mod_o
);
    logic [RATIO_W-1:0] step_q, mod_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            step_q <= RATIO_W'(STEP_RST);
            mod_q  <= RATIO_W'(MOD_RST);
        end else if (we_i) begin
            if (addr_i == OFS_STEP) step_q <= wfield_i;
            if (addr_i == OFS_MOD)  mod_q  <= wfield_i;
        end
    end

    assign step_o = step_q;
    assign mod_o  = mod_q;

    assert_step_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && addr_i == OFS_STEP) |=> $stable(step_q));
    assert_mod_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && addr_i == OFS_MOD) |=> $stable(mod_q));
endmodule

// File: rtl/rtfc_accum.sv
module rtfc_accum
    import rtfc_pkg::*;
#(
    parameter int RATIO_W = 12,
    parameter int CNT_W = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [RATIO_W-1:0]   step_i,
    input  logic [RATIO_W-1:0]   mod_i,
    output logic [CNT_W-1:0]     count_o
);
    logic [RATIO_W-1:0] acc_q, acc_d, acc_eff;
    logic [RATIO_W:0]   sum, rem, mod_x;
    logic [CNT_W-1:0]   count_q, count_d;
    step_e              step;

    assign mod_x = {1'b0, mod_i};

    always_comb begin
        if (mod_i == '0)
            acc_eff = '0;
        else if (acc_q >= mod_i)
            acc_eff = mod_i - 1'b1;
        else
            acc_eff = acc_q;
        sum = {1'b0, acc_eff} + {1'b0, step_i};
        rem = sum - mod_x;
        if (sum < mod_x)
            step = STEP_HOLD;
        else if (rem < mod_x)
            step = STEP_ADVANCE;
        else
            step = STEP_RESYNC;
    end

    always_comb begin
        acc_d   = acc_q;
        count_d = count_q;
        unique case (step)
            STEP_HOLD: acc_d = sum[RATIO_W-1:0];
            STEP_ADVANCE: begin
                acc_d   = rem[RATIO_W-1:0];
                count_d = count_q + CNT_W'(1);
            end
            STEP_RESYNC: begin
                acc_d   = '0;
                count_d = count_q + CNT_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q   <= '0;
            count_q <= '0;
        end else begin
            acc_q   <= acc_d;
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

    assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));
    assert_acc_below_mod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mod_i != '0) |=> (acc_q < $past(mod_i)));
    assert_every_clock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i >= mod_i) |=> (count_q == $past(count_q) + CNT_W'(1)));
endmodule

// File: rtl/rtfc_readout.sv
module rtfc_readout
    import rtfc_pkg::*;
#(
    parameter int RATIO_W = 12,
    parameter int REG_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 re_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [2*REG_W-1:0]   count_i,
    input  logic [RATIO_W-1:0]   step_i,
    input  logic [RATIO_W-1:0]   mod_i,
    output logic [REG_W-1:0]     rdata_o
);
    logic [REG_W-1:0] rdata_q, hi_hold_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q   <= '0;
            hi_hold_q <= '0;
        end else if (re_i) begin
            unique case (addr_i)
                OFS_CNT_LO: begin
                    rdata_q   <= count_i[REG_W-1:0];
                    hi_hold_q <= count_i[2*REG_W-1:REG_W];
                end
                OFS_CNT_HI: rdata_q <= hi_hold_q;
                OFS_STEP:   rdata_q <= REG_W'(step_i);
                OFS_MOD:    rdata_q <= REG_W'(mod_i);
                default:    rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign rdata_o = rdata_q;

    assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !re_i |=> (rdata_q == '0));
    assert_hi_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(re_i && addr_i == OFS_CNT_LO) |=> $stable(hi_hold_q));
endmodule

// File: rtl/rt_frac_counter.sv
module rt_frac_counter
    import rtfc_pkg::*;
#(
    parameter int RATIO_W = 12,
    parameter int REG_W = 32,
    parameter int STEP_RST = 4,
    parameter int MOD_RST = 25
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_we_i,
    input  logic               bus_re_i,
    input  logic [5:0]         bus_addr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic [2*REG_W-1:0] mc_count_o
);
    localparam int CNT_W = 2 * REG_W;

    logic [RATIO_W-1:0] step_w, mod_w;
    logic [CNT_W-1:0]   count_w;
    logic               unused_wbits;

    assign unused_wbits = ^bus_wdata_i[REG_W-1:RATIO_W];

    rtfc_ratio_regs #(.RATIO_W(RATIO_W), .STEP_RST(STEP_RST), .MOD_RST(MOD_RST)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
        .wfield_i(bus_wdata_i[RATIO_W-1:0]), .step_o(step_w), .mod_o(mod_w));

    rtfc_accum #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_accum (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_w), .mod_i(mod_w),
        .count_o(count_w));

    rtfc_readout #(.RATIO_W(RATIO_W), .REG_W(REG_W)) u_read (
        .clk_i(clk_i), .rst_ni(rst_ni), .re_i(bus_re_i), .addr_i(bus_addr_i),
        .count_i(count_w), .step_i(step_w), .mod_i(mod_w), .rdata_o(bus_rdata_o));

    assign mc_count_o = count_w;
endmodule

// File: tb/rt_frac_counter_tb_top.sv
`timescale 1ns/1ps
module rt_frac_counter_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        we = 1'b0, re = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] count;

    int total = 0, bad = 0;
    string cur_req = "R1";

    always #2 clk_i = ~clk_i;

    rt_frac_counter dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(we), .bus_re_i(re),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .mc_count_o(count));

    // behavioural reference model
    longint unsigned m_count = 0;
    int m_num = 4, m_den = 25, m_acc = 0, n_edges = 0;
    logic [31:0] m_hi = '0, m_rd = '0;

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_count = 0; m_num = 4; m_den = 25; m_acc = 0; m_hi = '0; m_rd = '0; n_edges = 0;
        end else begin
            int e, s;
            n_edges++;
            if (re) begin
                case (addr)
                    6'h00: begin m_rd = m_count[31:0]; m_hi = m_count[63:32]; end
                    6'h04: m_rd = m_hi;
                    6'h10: m_rd = 32'(m_num);
                    6'h14: m_rd = 32'(m_den);
                    default: m_rd = '0;
                endcase
            end else m_rd = '0;
            if (m_den == 0) e = 0;
            else if (m_acc >= m_den) e = m_den - 1;
            else e = m_acc;
            s = e + m_num;
            if (s >= m_den) begin
                m_count++;
                m_acc = (s - m_den < m_den) ? s - m_den : 0;
            end else m_acc = s;
            if (we && addr == 6'h10) m_num = int'(wdata[11:0]);
            if (we && addr == 6'h14) m_den = int'(wdata[11:0]);
        end
    end

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model (R2, R3, R6, R7, R9)
    always @(negedge clk_i) if (rst_ni) begin
        check({cur_req, " count"}, count, m_count);
        check({cur_req, " rdata"}, rdata, m_rd);
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk_i); we = 1'b1; addr = a; wdata = d;
        @(negedge clk_i); we = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk_i); re = 1'b1; addr = a;
        @(negedge clk_i); re = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    initial begin
        #100000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1 count reset", count, 0);
        check("R1 rdata reset", rdata, 0);
        rst_ni = 1'b1;
        cur_req = "R1";
        rd_chk(6'h10, 32'd4, "R1 step default");
        rd_chk(6'h14, 32'd25, "R1 mod default");
        rd_chk(6'h04, 32'd0, "R8 high capture zero after reset");
        cur_req = "R2";
        idle(240);
        check("R2 floor(k*4/25)", count, longint'((n_edges * 4) / 25));
        // R4 / R5: only low 12 bits land
        cur_req = "R4";
        wr(6'h10, 32'hFFFF_F040);
        rd_chk(6'h10, 32'h0000_0040, "R4 step field only");
        cur_req = "R5";
        wr(6'h14, 32'hABC0_007D);
        rd_chk(6'h14, 32'h0000_007D, "R5 mod field only");
        idle(300);
        // R9: unmapped reads and writes
        cur_req = "R9";
        wr(6'h08, 32'h0000_0001);
        rd_chk(6'h08, 32'd0, "R9 unmapped read zero");
        rd_chk(6'h10, 32'h40, "R4 write elsewhere ignored");
        rd_chk(6'h14, 32'h7D, "R5 write elsewhere ignored");
        // R8: low read returns pre-edge count, while counting
        cur_req = "R8";
        begin
            longint unsigned pre;
            @(negedge clk_i); re = 1'b1; addr = 6'h00; pre = count;
            @(negedge clk_i); re = 1'b0;
            check("R8 low half pre-edge", rdata, pre & 64'hFFFF_FFFF);
        end
        rd_chk(6'h04, 32'd0, "R8 high half captured");
        // other ratios from the table
        cur_req = "R2";
        wr(6'h10, 32'd768); wr(6'h14, 32'd1625); idle(2000);
        wr(6'h10, 32'd75);  wr(6'h14, 32'd244);  idle(1000);
        // R6: large remainder then a small modulus
        cur_req = "R6";
        wr(6'h10, 32'd1000); wr(6'h14, 32'd1001); idle(7);
        wr(6'h14, 32'd5); wr(6'h10, 32'd1); idle(40);
        // same-cycle write and read of a count step
        @(negedge clk_i); we = 1'b1; addr = 6'h14; wdata = 32'd3; re = 1'b0;
        @(negedge clk_i); we = 1'b0; re = 1'b1; addr = 6'h00;
        @(negedge clk_i); re = 1'b0;
        idle(20);
        // R7: step >= modulus, and modulus zero
        cur_req = "R7";
        wr(6'h10, 32'd7); wr(6'h14, 32'd3);
        begin
            longint unsigned c0;
            c0 = count; idle(10);
            check("R7 advance every clock", count, c0 + 10);
        end
        wr(6'h14, 32'd0);
        begin
            longint unsigned c1;
            c1 = count; idle(10);
            check("R7 modulus zero", count, c1 + 10);
        end
        // R3: mid-run reset check via R1 again
        cur_req = "R3";
        wr(6'h10, 32'd1); wr(6'h14, 32'd2); idle(50);
        @(negedge clk_i); rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1 count after second reset", count, 0);
        rst_ni = 1'b1;
        rd_chk(6'h10, 32'd4, "R1 step after second reset");
        idle(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule